// File: doc/BRIEF.md
# Per-Source Buffer Completion Scheduler

This block sits in front of a compute engine that works on packets grouped by the node they came from. Each originating node has its own buffer slot, and every slot expects a fixed number of packets. That number is sized for the worst case and programmed ahead of time. The scheduler counts arrivals for each slot. A slot is complete when its count reaches the programmed value. Complete slots are handed to the engine one index at a time. Packet payloads and the engine itself are outside this block; only slot indices and counts pass through it.

There are two dispatch paths. The normal path follows a processing order that a controller appends to an order list. Slots marked urgent take the second path: they join a first-in-first-out urgent queue in the same edge that counts their final packet. The engine drains that queue before it takes the next entry of the order list. This lets results that must travel farthest leave early, so their send latency overlaps the remaining work. An urgent slot that also sits on the order list is stepped over there once it has been dispatched, so no slot is processed twice per step.

A step-restart pulse clears every count, the dispatched marks, the urgent queue, the read position of the order list and the overflow flag. Slot configuration and the order list contents survive a step restart.

Top module: `bufDispatchSched`

## Requirements
- R1: A packet with `pktValid`=1 and source `pktSrc`=i adds one to the count of slot i. Slot i is complete when its count equals its programmed expected count (1 to 255). An incomplete slot is never dispatched.
- R2: A cycle with `cfgWe`=1 sets the expected count of slot `cfgIdx` to `cfgExpect` and its urgent mark to `cfgPrio` (1 = urgent). Both take effect from the next cycle.
- R3: A packet for a slot whose count already equals its expected count sets `overflowErr`. The flag stays set until a step restart or reset.
- R4: An urgent slot enters the urgent queue in the edge that counts its last packet. From the next cycle it is offered with `dispValid`=1, `dispIdx`=its index and `dispPrio`=1, unless older urgent entries are still ahead of it.
- R5: While the urgent queue holds entries, the offer is always the oldest queued slot with `dispPrio`=1. The order list is not consulted until the queue is empty.
- R6: With the urgent queue empty, the offer is the slot at the current order-list position, with `dispPrio`=0, and only once that slot is complete. If it is incomplete, nothing is offered, even when later list slots are complete.
- R7: If the slot at the current order-list position was already dispatched in this step, the position advances by one in that cycle with no offer. No slot is dispatched twice per step.
- R8: A dispatch happens only in a cycle with `dispValid`=1 and `engReady`=1. With `engReady`=0 the offered slot remains pending.
- R9: In a cycle with `stepRestart`=1, nothing is offered. After that edge, all counts, dispatched marks, the urgent queue, the list position and `overflowErr` are cleared, while configuration and list contents are kept.
- R10: A cycle with `listWe`=1 appends `listData` as the next order-list entry, up to `LIST_DEPTH` entries. Reset empties the list.
- R11: After reset, `dispValid` and `overflowErr` are 0 and every slot is unconfigured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepRestart | input | 1 | Start of a new step: clears per-step state |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIdx | input | IDX_W | Slot index being configured |
| cfgExpect | input | CNT_W | Expected packet count for that slot |
| cfgPrio | input | 1 | Urgent mark for that slot |
| listWe | input | 1 | Append strobe for the order list |
| listData | input | IDX_W | Slot index appended to the order list |
| pktValid | input | 1 | One packet arrives this cycle |
| pktSrc | input | IDX_W | Originating node, which is also the slot index |
| engReady | input | 1 | Engine can accept a slot this cycle |
| dispValid | output | 1 | A slot is offered to the engine |
| dispIdx | output | IDX_W | Offered slot index |
| dispPrio | output | 1 | Offer comes from the urgent queue |
| overflowErr | output | 1 | Sticky: packet arrived for a complete slot |

## Verification
The bench builds the block with its default values: 32 slots, 8-bit counts and a 32-entry order list. It programs eight slots of small varying counts, two of them urgent and also listed, plus slot 31 with the maximum count of 255. This brings within reach urgent overtaking of the list, stepping over listed urgent slots, list stalls behind an incomplete head, the highest index and the full count width. A behavioural queue model runs alongside and is compared every cycle. Its input pattern includes engine back-pressure, an overflow packet, and a step restart followed by a second, differently ordered arrival pattern.

// File: rtl/schedPkg.sv
package schedPkg;
  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic popPq;     // urgent head dispatched this cycle
    logic advList;   // order-list position moves on
    logic markList;  // list head dispatched this cycle
  } schedStrobe_t;
endpackage

// File: rtl/schedDatapath.sv
module schedDatapath
  import schedPkg::*;
#(
  parameter int NUM_BUF    = 32,
  parameter int CNT_W      = 8,
  parameter int LIST_DEPTH = 32,
  localparam int IDX_W  = $clog2(NUM_BUF),
  localparam int LIDX_W = $clog2(LIST_DEPTH),
  localparam int LPTR_W = $clog2(LIST_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepRestart,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [CNT_W-1:0] cfgExpect,
  input  logic             cfgPrio,
  input  logic             listWe,
  input  logic [IDX_W-1:0] listData,
  input  logic             pktValid,
  input  logic [IDX_W-1:0] pktSrc,
  input  schedStrobe_t     strb,
  output logic             pqEmpty,
  output logic [IDX_W-1:0] pqHead,
  output logic             listAvail,
  output logic [IDX_W-1:0] listHead,
  output logic             listHeadComplete,
  output logic             listHeadDone,
  output logic             overflowErr
);
  logic [CNT_W-1:0]  expectMem [NUM_BUF];
  logic [CNT_W-1:0]  countMem  [NUM_BUF];
  logic [NUM_BUF-1:0] prioBits, doneBits;
  logic [IDX_W-1:0]  listMem [LIST_DEPTH];
  logic [LPTR_W-1:0] listLen, listRd;
  logic [IDX_W-1:0]  pqMem [NUM_BUF];
  logic [IDX_W-1:0]  pqRdPtr, pqWrPtr;
  logic [IDX_W:0]    pqCnt;

  logic pktFull, pktLast, pushPq;

  always_comb begin
    pktFull = (countMem[pktSrc] == expectMem[pktSrc]);
    pktLast = pktValid && !pktFull && ((countMem[pktSrc] + CNT_W'(1)) == expectMem[pktSrc]);
    pushPq  = pktLast && prioBits[pktSrc];
  end

  assign pqEmpty          = (pqCnt == '0);
  assign pqHead           = pqMem[pqRdPtr];
  assign listAvail        = (listRd < listLen);
  assign listHead         = listMem[listRd[LIDX_W-1:0]];
  assign listHeadComplete = (countMem[listHead] == expectMem[listHead]);
  assign listHeadDone     = doneBits[listHead];

  // Per-slot configuration, counts and dispatched marks.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        expectMem[i] <= '0;
        countMem[i]  <= '0;
      end
      prioBits <= '0;
      doneBits <= '0;
    end else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (cfgWe && cfgIdx == IDX_W'(i)) begin
          expectMem[i] <= cfgExpect;
          prioBits[i]  <= cfgPrio;
        end
        if (stepRestart) begin
          countMem[i] <= '0;
          doneBits[i] <= 1'b0;
        end else begin
          if (pktValid && !pktFull && pktSrc == IDX_W'(i))
            countMem[i] <= countMem[i] + CNT_W'(1);
          if ((strb.popPq && pqHead == IDX_W'(i)) ||
              (strb.markList && listHead == IDX_W'(i)))
            doneBits[i] <= 1'b1;
        end
      end
    end
  end

  // Order list: append on write, read position per step.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      listLen <= '0;
      listRd  <= '0;
    end else begin
      if (listWe && listLen < LPTR_W'(LIST_DEPTH)) begin
        listMem[listLen[LIDX_W-1:0]] <= listData;
        listLen <= listLen + LPTR_W'(1);
      end
      if (stepRestart)       listRd <= '0;
      else if (strb.advList) listRd <= listRd + LPTR_W'(1);
    end
  end

  // Urgent queue, one entry per slot at most per step.
  always_ff @(posedge clk) begin
    if (!rstN || stepRestart) begin
      pqRdPtr <= '0;
      pqWrPtr <= '0;
      pqCnt   <= '0;
    end else begin
      if (pushPq) begin
        pqMem[pqWrPtr] <= pktSrc;
        pqWrPtr <= (pqWrPtr == IDX_W'(NUM_BUF - 1)) ? '0 : pqWrPtr + IDX_W'(1);
      end
      if (strb.popPq)
        pqRdPtr <= (pqRdPtr == IDX_W'(NUM_BUF - 1)) ? '0 : pqRdPtr + IDX_W'(1);
      pqCnt <= pqCnt + (pushPq ? 1'b1 : 1'b0) - (strb.popPq ? 1'b1 : 1'b0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stepRestart)              overflowErr <= 1'b0;
    else if (pktValid && pktFull)          overflowErr <= 1'b1;
  end

  assert_urgent_once_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.popPq |-> !doneBits[pqHead]);
  assert_list_once_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.markList |-> !doneBits[listHead]);
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.popPq |-> pqCnt != '0);
  assert_list_complete_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.markList |-> listHeadComplete);
  assert_no_overflow_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (overflowErr && !stepRestart) |=> overflowErr);
  assert_restart_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    stepRestart |=> (!overflowErr && pqCnt == '0 && listRd == '0));
  assert_list_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    listRd <= listLen);
endmodule

// File: rtl/schedControl.sv
module schedControl
  import schedPkg::*;
#(
  parameter int NUM_BUF = 32,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepRestart,
  input  logic             engReady,
  input  logic             pqEmpty,
  input  logic [IDX_W-1:0] pqHead,
  input  logic             listAvail,
  input  logic [IDX_W-1:0] listHead,
  input  logic             listHeadComplete,
  input  logic             listHeadDone,
  output schedStrobe_t     strb,
  output logic             dispValid,
  output logic [IDX_W-1:0] dispIdx,
  output logic             dispPrio
);
  always_comb begin
    strb      = '0;
    dispValid = 1'b0;
    dispIdx   = '0;
    dispPrio  = 1'b0;
    if (!stepRestart) begin
      if (!pqEmpty) begin
        dispValid  = 1'b1;
        dispIdx    = pqHead;
        dispPrio   = 1'b1;
        strb.popPq = engReady;
      end else if (listAvail) begin
        if (listHeadDone) begin
          strb.advList = 1'b1;
        end else if (listHeadComplete) begin
          dispValid     = 1'b1;
          dispIdx       = listHead;
          strb.advList  = engReady;
          strb.markList = engReady;
        end
      end
    end
  end

  assert_one_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.popPq && strb.advList));
  assert_handshake_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popPq || strb.markList) |-> (dispValid && engReady));
endmodule

// File: rtl/bufDispatchSched.sv
module bufDispatchSched
  import schedPkg::*;
#(
  parameter int NUM_BUF    = 32,
  parameter int CNT_W      = 8,
  parameter int LIST_DEPTH = 32,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepRestart,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [CNT_W-1:0] cfgExpect,
  input  logic             cfgPrio,
  input  logic             listWe,
  input  logic [IDX_W-1:0] listData,
  input  logic             pktValid,
  input  logic [IDX_W-1:0] pktSrc,
  input  logic             engReady,
  output logic             dispValid,
  output logic [IDX_W-1:0] dispIdx,
  output logic             dispPrio,
  output logic             overflowErr
);
  schedStrobe_t     strb;
  logic             pqEmpty, listAvail, listHeadComplete, listHeadDone;
  logic [IDX_W-1:0] pqHead, listHead;

  schedDatapath #(.NUM_BUF(NUM_BUF), .CNT_W(CNT_W), .LIST_DEPTH(LIST_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .stepRestart(stepRestart),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgExpect(cfgExpect), .cfgPrio(cfgPrio),
    .listWe(listWe), .listData(listData),
    .pktValid(pktValid), .pktSrc(pktSrc), .strb(strb),
    .pqEmpty(pqEmpty), .pqHead(pqHead), .listAvail(listAvail), .listHead(listHead),
    .listHeadComplete(listHeadComplete), .listHeadDone(listHeadDone),
    .overflowErr(overflowErr)
  );

  schedControl #(.NUM_BUF(NUM_BUF)) uCtl (
    .clk(clk), .rstN(rstN), .stepRestart(stepRestart), .engReady(engReady),
    .pqEmpty(pqEmpty), .pqHead(pqHead), .listAvail(listAvail), .listHead(listHead),
    .listHeadComplete(listHeadComplete), .listHeadDone(listHeadDone),
    .strb(strb), .dispValid(dispValid), .dispIdx(dispIdx), .dispPrio(dispPrio)
  );
endmodule

// File: tb/tb_bufDispatchSched.sv
module tb_bufDispatchSched;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0, stepRestart = 1'b0, cfgWe = 1'b0, cfgPrio = 1'b0;
  logic listWe = 1'b0, pktValid = 1'b0, engReady = 1'b0;
  logic [4:0] cfgIdx = '0, listData = '0, pktSrc = '0;
  logic [7:0] cfgExpect = '0;
  logic dispValid, dispPrio, overflowErr;
  logic [4:0] dispIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  bufDispatchSched dut (
    .clk(clk), .rstN(rstN), .stepRestart(stepRestart),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgExpect(cfgExpect), .cfgPrio(cfgPrio),
    .listWe(listWe), .listData(listData), .pktValid(pktValid), .pktSrc(pktSrc),
    .engReady(engReady), .dispValid(dispValid), .dispIdx(dispIdx),
    .dispPrio(dispPrio), .overflowErr(overflowErr)
  );

  // Behavioural reference state
  int mCnt[NB], mExp[NB];
  bit mPrio[NB], mDone[NB];
  int mList[$];
  int mPq[$];
  int mRd;
  bit mOvf, mJustPushed;
  string phaseTag = "R11";

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit eV, eP; int eI; string tag;
    eV = 0; eP = 0; eI = 0;
    if (!stepRestart) begin
      if (mPq.size() > 0) begin eV = 1; eI = mPq[0]; eP = 1; end
      else if (mRd < mList.size() && !mDone[mList[mRd]] &&
               mCnt[mList[mRd]] == mExp[mList[mRd]]) begin eV = 1; eI = mList[mRd]; end
    end
    if (phaseTag != "")               tag = phaseTag;
    else if (mPq.size() > 0)          tag = mJustPushed ? "R4" : "R5";
    else if (!engReady && eV)         tag = "R8";
    else if (mRd < mList.size() && mDone[mList[mRd]]) tag = "R7";
    else                              tag = "R6";
    chk(dispValid == eV, {tag, " dispValid"}, int'(dispValid), int'(eV));
    if (eV) begin
      chk(int'(dispIdx) == eI, {tag, " dispIdx"}, int'(dispIdx), eI);
      chk(dispPrio == eP, {tag, " dispPrio"}, int'(dispPrio), int'(eP));
    end
    chk(overflowErr == mOvf, "R3 overflowErr", int'(overflowErr), int'(mOvf));
  endtask

  task automatic modelEdge();
    mJustPushed = 0;
    if (stepRestart) begin
      for (int i = 0; i < NB; i++) begin mCnt[i] = 0; mDone[i] = 0; end
      mPq.delete(); mRd = 0; mOvf = 0;
    end else begin
      if (mPq.size() > 0) begin
        if (engReady) begin mDone[mPq[0]] = 1; void'(mPq.pop_front()); end
      end else if (mRd < mList.size()) begin
        if (mDone[mList[mRd]]) mRd++;
        else if (mCnt[mList[mRd]] == mExp[mList[mRd]] && engReady) begin
          mDone[mList[mRd]] = 1; mRd++;
        end
      end
      if (pktValid) begin
        if (mCnt[pktSrc] == mExp[pktSrc]) mOvf = 1;
        else begin
          mCnt[pktSrc]++;
          if (mCnt[pktSrc] == mExp[pktSrc] && mPrio[pktSrc]) begin
            mPq.push_back(int'(pktSrc)); mJustPushed = 1;
          end
        end
      end
    end
    if (cfgWe) begin mExp[cfgIdx] = int'(cfgExpect); mPrio[cfgIdx] = cfgPrio; end
    if (listWe && mList.size() < 32) mList.push_back(int'(listData));
  endtask

  task automatic tick();
    compare();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    pktValid = 0; cfgWe = 0; listWe = 0; stepRestart = 0;
  endtask

  task automatic sendPkt(input int src);
    pktValid = 1; pktSrc = 5'(src); tick();
  endtask

  task automatic cfgSlot(input int idx, input int expv, input bit pr);
    cfgWe = 1; cfgIdx = 5'(idx); cfgExpect = 8'(expv); cfgPrio = pr; tick();
  endtask

  task automatic appendList(input int idx);
    listWe = 1; listData = 5'(idx); tick();
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int expv[8] = '{2, 3, 1, 4, 2, 1, 3, 5};
    int order[9] = '{0, 1, 3, 2, 4, 5, 6, 7, 31};
    for (int i = 0; i < NB; i++) begin mCnt[i] = 0; mExp[i] = 0; mPrio[i] = 0; mDone[i] = 0; end
    mRd = 0; mOvf = 0; mJustPushed = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(dispValid == 1'b0, "R11 dispValid after reset", int'(dispValid), 0);
    chk(overflowErr == 1'b0, "R11 overflowErr after reset", int'(overflowErr), 0);
    rstN = 1;
    tick();

    phaseTag = "R2";
    for (int i = 0; i < 8; i++) cfgSlot(i, expv[i], (i == 3 || i == 6));
    cfgSlot(31, 255, 0);
    phaseTag = "R10";
    for (int i = 0; i < 9; i++) appendList(order[i]);

    // R1: counting with the engine held off
    phaseTag = "R1";
    engReady = 0;
    for (int r = 0; r < 5; r++)
      for (int i = 0; i < 8; i++)
        if (r < expv[i]) sendPkt(i);

    // Urgent drain, list order, skips, back-pressure (R5 R6 R7 R8)
    phaseTag = "";
    for (int c = 0; c < 30; c++) begin engReady = c[0]; tick(); end
    engReady = 1;
    // Boundary: full count on the highest slot (R1 R6)
    for (int k = 0; k < 255; k++) sendPkt(31);
    repeat (4) tick();

    // R3: packet to a complete slot
    sendPkt(0);
    repeat (3) tick();

    // R9: step restart, then a second arrival pattern
    stepRestart = 1;
    phaseTag = "R9";
    tick();
    tick();
    phaseTag = "";
    for (int k = 0; k < 3; k++) sendPkt(1);
    sendPkt(2);
    tick();
    for (int k = 0; k < 3; k++) sendPkt(6);   // urgent overtakes stalled list (R4)
    repeat (3) tick();
    for (int k = 0; k < 2; k++) sendPkt(0);
    repeat (3) tick();
    for (int k = 0; k < 4; k++) sendPkt(3);
    repeat (4) tick();
    for (int k = 0; k < 2; k++) sendPkt(4);
    sendPkt(5);
    for (int k = 0; k < 5; k++) sendPkt(7);
    repeat (10) tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule